// File: doc/BRIEF.md
# Parallel ROM Byte Read Controller

This block sits on the host side of an asynchronous byte-wide ROM with a 19-bit address bus and an 8-bit data bus. The host hands it one address per request. The controller then drives the address and pulls the chip-select line low. A fixed number of cycles later it pulls the output-gate line low. It waits until every access-time limit of the part has passed, captures the byte, and returns the byte with a one-cycle completion pulse. It then releases both control lines and holds them high for the bus float time before any new access starts.

All part timing is given in nanoseconds together with the clock period in picoseconds. The controller turns each limit into a whole number of clock cycles at elaboration. The same source therefore covers any speed grade and any clock rate. Between reads the chip-select line stays high, which keeps the ROM in its low-power standby state with its outputs floating.

Top module: `rom_rd_ctrl`

## Requirements
- R1: During and after reset, `rom_ce_n` and `rom_oe_n` are 1, `ready` is 1 and `done` is 0. While no read is in progress, `rom_ce_n` stays 1.
- R2: A read is accepted on a clock edge where `req` and `ready` are both 1. `ready` is 0 from the edge after acceptance until the controller is idle again.
- R3: While `rom_ce_n` is 0, `rom_addr` equals the address accepted with the request and does not change.
- R4: `rom_oe_n` falls exactly G_LAG cycles after `rom_ce_n` falls, and `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R5: The byte is sampled at the end of the WAIT-th cycle with `rom_ce_n` low, where WAIT = max(ACC, G_LAG + OE). `done` rises WAIT + 1 clock edges after the accepting edge, and `rd_data` equals the ROM byte at that address.
- R6: `done` is a single-cycle pulse. `rd_data` holds its value after `done` until the next sample.
- R7: After a sample, `rom_ce_n` stays 1 for at least DF cycles before it falls again.
- R8: Each time limit converts to cycles as ceil(ns * 1000 / CLK_PERIOD_PS), with a floor of 1. At 4 ns and the 70/35/30 ns defaults this gives ACC = 18, OE = 9, DF = 8, and WAIT = 18 with G_LAG = 2.
- R9: If `req` is held high across a completion, the next read is accepted once the float gap has passed and returns the correct byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request |
| req_addr | input | 19 | Byte address of the request |
| ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | 8 | Byte read from the ROM |
| rom_addr | output | 19 | Address bus to the ROM |
| rom_ce_n | output | 1 | Chip select, active low |
| rom_oe_n | output | 1 | Output gate, active low |
| rom_q | input | 8 | Data bus from the ROM |

## Verification
The hardest case to reach from the ports is a read that starts immediately after the previous one. Only that case exercises the float gap, and the gap is only worth checking when it is the sole thing delaying the next access. The bench reaches it by raising `req` again in the same cycle it sees `done`, both in directed cases and in random runs whose idle gap is sometimes zero. Its ROM model returns the inverted byte whenever the address, select or gate time since the last change is shorter than the part allows. A sample taken even one cycle early therefore shows up as a data mismatch.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } rom_ctl_t;

    // Round a delay up to whole clock cycles, never less than one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
    import rom_rd_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 18,
    parameter int unsigned DF_CYC   = 8,
    parameter int unsigned G_LAG    = 2,
    parameter int unsigned CNT_W    = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    output logic     ready,
    output logic     accept,
    output logic     sample,
    output rom_ctl_t ctl
);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] DF_LAST   = CNT_W'(DF_CYC - 1);
    localparam logic [CNT_W-1:0] LAG_CNT   = CNT_W'(G_LAG);

    rd_state_e        state;
    logic [CNT_W-1:0] cnt;

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req;
    assign sample = (state == ST_ACCESS) && (cnt == WAIT_LAST);

    always_comb begin
        ctl.ce_n = !(state == ST_ACCESS);
        ctl.oe_n = !((state == ST_ACCESS) && (cnt >= LAG_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req) state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (cnt == WAIT_LAST) begin
                        state <= ST_RELEASE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RELEASE: begin
                    if (cnt == DF_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R5: the access counter never runs past the sample point
    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACCESS) |-> (cnt <= WAIT_LAST));

    // R2: a request is only taken from the idle state
    assert_accept_idle_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_ACCESS));
endmodule

// File: rtl/rom_rd_addr_hold.sv
module rom_rd_addr_hold #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    always_ff @(posedge clk) begin
        if (rst)         addr_out <= '0;
        else if (accept) addr_out <= addr_in;
    end
endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_q,
    output logic [DATA_W-1:0] data,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            done <= 1'b0;
        end else begin
            done <= sample;
            if (sample) data <= bus_q;
        end
    end

    // R6: the completion strobe lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: captured data holds between samples
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(sample) |-> $stable(data));
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned T_ACC_NS      = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_DF_NS       = 30,
    parameter int unsigned G_LAG         = 2,
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_q
);
    localparam int unsigned ACC_CYC  = ns_to_cycles(T_ACC_NS, CLK_PERIOD_PS);
    localparam int unsigned OE_CYC   = ns_to_cycles(T_OE_NS, CLK_PERIOD_PS);
    localparam int unsigned DF_CYC   = ns_to_cycles(T_DF_NS, CLK_PERIOD_PS);
    localparam int unsigned WAIT_CYC = max_u(ACC_CYC, G_LAG + OE_CYC);
    localparam int unsigned CNT_W    = $clog2(max_u(WAIT_CYC, DF_CYC) + 1);

    logic     accept;
    logic     sample;
    rom_ctl_t ctl;

    rom_rd_seq #(
        .WAIT_CYC(WAIT_CYC),
        .DF_CYC  (DF_CYC),
        .G_LAG   (G_LAG),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .ready (ready),
        .accept(accept),
        .sample(sample),
        .ctl   (ctl)
    );

    rom_rd_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .addr_in (req_addr),
        .addr_out(rom_addr)
    );

    rom_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .sample(sample),
        .bus_q (rom_q),
        .data  (rd_data),
        .done  (done)
    );

    assign rom_ce_n = ctl.ce_n;
    assign rom_oe_n = ctl.oe_n;

    // Run-length counters used only by the checks below.
    logic [CNT_W-1:0] hi_run;
    logic [CNT_W-1:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= CNT_W'(DF_CYC);
            lo_run <= '0;
        end else begin
            if (!rom_ce_n)                       hi_run <= '0;
            else if (hi_run != CNT_W'(DF_CYC))   hi_run <= hi_run + 1'b1;
            if (rom_ce_n)                        lo_run <= '0;
            else if (lo_run != CNT_W'(WAIT_CYC)) lo_run <= lo_run + 1'b1;
        end
    end

    // R7: float gap before select falls again
    assert_float_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_ce_n) |-> (hi_run >= CNT_W'(DF_CYC)));

    // R4: gate lags select by G_LAG cycles
    assert_gate_lag_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_oe_n) |-> (lo_run == CNT_W'(G_LAG)));

    // R4: gate only with select
    assert_gate_in_select_R4: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !rom_ce_n);

    // R3: address stable across an access
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

    // R1: standby whenever idle
    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> rom_ce_n);

    // R5: data comes from a cycle with both controls low
    assert_sample_window_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!rom_ce_n && !rom_oe_n));
endmodule

// File: tb/tb_rom_rd_ctrl.sv
module tb_rom_rd_ctrl;
    localparam int unsigned PER_PS = 4000;
    localparam int unsigned ACC_NS = 70;
    localparam int unsigned OE_NS  = 35;
    localparam int unsigned DF_NS  = 30;
    localparam int unsigned LAG    = 2;

    function automatic int unsigned to_cyc(input int unsigned ns);
        int unsigned c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int unsigned B_ACC  = to_cyc(ACC_NS);
    localparam int unsigned B_OE   = to_cyc(OE_NS);
    localparam int unsigned B_DF   = to_cyc(DF_NS);
    localparam int unsigned B_WAIT = (B_ACC > LAG + B_OE) ? B_ACC : LAG + B_OE;

    function automatic logic [7:0] rom_byte(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [18:0] req_addr = '0;
    logic        ready, done;
    logic [7:0]  rd_data;
    logic [18:0] rom_addr;
    logic        rom_ce_n, rom_oe_n;
    logic [7:0]  rom_q = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rom_rd_ctrl #(
        .CLK_PERIOD_PS(PER_PS), .T_ACC_NS(ACC_NS), .T_OE_NS(OE_NS),
        .T_DF_NS(DF_NS), .G_LAG(LAG)
    ) dut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .ready(ready), .done(done), .rd_data(rd_data),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_q(rom_q)
    );

    task automatic check(input bit ok, input string req_tag,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, actual, expected);
        end
    endtask

    // ROM model: wrong byte unless every access time has elapsed
    int          e_cnt = 0, g_cnt = 0, a_cnt = 0;
    logic [18:0] prev_addr = '0;
    always @(negedge clk) begin
        e_cnt = rom_ce_n ? 0 : ((e_cnt < 1000) ? e_cnt + 1 : e_cnt);
        g_cnt = (rom_oe_n || rom_ce_n) ? 0 : ((g_cnt < 1000) ? g_cnt + 1 : g_cnt);
        a_cnt = (rom_addr != prev_addr) ? 1 : ((a_cnt < 1000) ? a_cnt + 1 : a_cnt);
        prev_addr = rom_addr;
        if (e_cnt >= int'(B_ACC) && g_cnt >= int'(B_OE) && a_cnt >= int'(B_ACC))
            rom_q = rom_byte(rom_addr);
        else
            rom_q = ~rom_byte(rom_addr);
    end

    // Bus monitors
    logic [18:0] exp_addr = '0;
    bit          in_read  = 1'b0;
    bit          seen_acc = 1'b0;
    int          hi_len = 0, lo_len = 0;
    logic        ce_d = 1'b1, oe_d = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (ce_d && !rom_ce_n) begin
                if (seen_acc) check(hi_len >= int'(B_DF), "R7 float gap", hi_len, B_DF);
                check(in_read, "R1 select only during read", 0, 1);
                seen_acc = 1'b1;
            end
            if (oe_d && !rom_oe_n)
                check(lo_len == int'(LAG), "R4 gate lag", lo_len, LAG);
            if (!rom_oe_n && rom_ce_n)
                check(1'b0, "R4 gate without select", 0, 1);
            if (!rom_ce_n && rom_addr != exp_addr)
                check(1'b0, "R3 address during access", rom_addr, exp_addr);
            hi_len = rom_ce_n ? hi_len + 1 : 0;
            lo_len = rom_ce_n ? 0 : lo_len + 1;
        end
        ce_d = rom_ce_n;
        oe_d = rom_oe_n;
    end

    // One read; req is left high if keep_req is set (back-to-back)
    task automatic do_read(input logic [18:0] a, input bit keep_req, input string tag);
        int lat;
        req_addr = a;
        req = 1'b1;
        while (!ready) @(negedge clk);
        exp_addr = a;
        in_read  = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(ready == 1'b0, "R2 busy after accept", ready, 0);
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        // R5 and R8: latency from the bench's own cycle conversion
        check(lat == int'(B_WAIT) + 1, {tag, " R5 latency"}, lat, B_WAIT + 1);
        check(rd_data == rom_byte(a), {tag, " R5 data"}, rd_data, rom_byte(a));
        in_read = 1'b0;
        if (keep_req) req = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R6 done pulse", done, 0);
        if (!keep_req)
            check(rd_data == rom_byte(a), "R6 data held", rd_data, rom_byte(a));
    endtask

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'h1F2E3D);
        repeat (3) @(negedge clk);
        check(rom_ce_n && rom_oe_n && ready && !done, "R1 reset state",
              {rom_ce_n, rom_oe_n, ready, done}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        check(rom_ce_n && ready, "R1 idle after reset", {rom_ce_n, ready}, 2'b11);

        // R8: conversion constants at 4 ns
        check(B_ACC == 18 && B_OE == 9 && B_DF == 8 && B_WAIT == 18,
              "R8 conversion", B_WAIT, 18);

        do_read(19'h00000, 1'b0, "low address");
        do_read(19'h7FFFF, 1'b0, "top address");
        do_read(19'h2A5C3, 1'b1, "R9 b2b first");
        do_read(19'h2A5C3, 1'b1, "R9 b2b same address");
        do_read(19'h15A3C, 1'b0, "R9 b2b new address");

        // R1: long idle keeps standby
        begin
            bit stayed = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!rom_ce_n || !rom_oe_n) stayed = 1'b0;
            end
            check(stayed, "R1 standby while idle", stayed, 1);
        end

        for (int n = 0; n < 60; n++) begin
            logic [18:0] a;
            int          gap;
            bit          b2b;
            a   = 19'($urandom);
            gap = int'($urandom_range(0, 4));
            b2b = (gap == 0);
            do_read(a, b2b, "random");
            repeat (gap) @(negedge clk);
        end
        req = 1'b0;
        repeat (20) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule